// File: doc/BRIEF.md
# Event Counter with Serial Snapshot Readout

The block counts pulses on an asynchronous event input with a free-running counter in the system clock domain. An external serial master reads that count through a small read-only SPI slave port. Each pulse adds one to the counter, and the counter wraps to zero after its all-ones value.

When the master pulls the active-low select line low, the live count is copied into a separate shift register. That copy is presented on the serial data output, most significant bit first. The copy advances by one bit on every falling edge of the serial clock, so the master samples on rising edges (mode 0). The counter keeps running while the transfer is in progress, and the word read is a consistent snapshot taken at the moment of selection.

The event, select and serial clock inputs are all brought into the system clock through two-stage synchronisers, and every edge is detected on the synchronised copies. The serial data output is driven only while a transfer is active. At other times it is released to high impedance, and a separate output-enable pin reports its state.

Top module: `evt_spi_counter`

## Requirements
- R1: Each rising edge of the event input increments the counter by exactly one. The counter wraps from its all-ones value to zero with no stall.
- R2: While the select line is high, the output enable is low and the serial data output is released to high impedance. The enable drops within a few clock cycles after select rises.
- R3: A falling edge on select copies the live count into the shift register. The output enable goes high on the third system clock edge after select falls, and not earlier. From that point the data output already carries the most significant bit of the copy.
- R4: Each falling serial clock edge during an active transfer moves the copy left by one bit, so the bits appear most significant first. Zeros follow the last bit.
- R5: Events that arrive during a transfer increment the live counter and leave the word being shifted unchanged.
- R6: An event whose rising edge reaches the block in the same cycle as the select falling edge is counted by the live counter but is not part of that snapshot.
- R7: Raising select before all bits have been shifted abandons the transfer. The next falling edge of select takes a fresh snapshot of the count.
- R8: An asynchronous active-low reset clears the counter and the shift register and leaves the output disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 1 | Asynchronous event input; each rising edge counts once |
| spi_csn_i | input | 1 | Active-low select from the serial master |
| spi_sck_i | input | 1 | Serial clock from the master, idle low |
| spi_miso_o | output | 1 | Serial data out, high impedance when not selected |
| spi_miso_oe_o | output | 1 | High while the serial data output is driven |

## Verification
The bench builds the block with a 4-bit counter, which is narrower than the 16-bit default. The counter wraps after 16 events, so a sweep that reads the word after every single event covers every counter value, including the all-ones to zero wrap, and checks each bit position of each value. The narrow width also keeps each read short, which leaves room to pulse events between serial clock edges, to line an event up exactly with the select edge, and to abandon a transfer partway and then start a new one.

// File: rtl/evt_spi_pkg.sv
package evt_spi_pkg;

  localparam int unsigned CNT_W_DEF   = 16;
  localparam int unsigned SYNC_N_DEF  = 2;

  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_SEND = 1'b1
  } sh_state_t;

endpackage

// File: rtl/evt_spi_rst_sync.sv
module evt_spi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/evt_spi_sync.sv
module evt_spi_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] st_q;
  logic [STAGES-1:0] st_n;

  always_comb begin
    st_n = {st_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= {STAGES{RST_VAL}};
    end else begin
      st_q <= st_n;
    end
  end

  assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/evt_spi_tally.sv
module evt_spi_tally #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt_lvl_i,
  output logic [W-1:0] cnt_o
);

  logic         prev_q;
  logic         rise;
  logic         cnt_en;
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_n;

  always_comb begin
    rise   = evt_lvl_i & ~prev_q;
    cnt_en = rise;
    cnt_n  = cnt_q + {{(W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= evt_lvl_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/evt_spi_shifter.sv
module evt_spi_shifter
  import evt_spi_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         csn_lvl_i,
  input  logic         sck_lvl_i,
  input  logic [W-1:0] par_i,
  output logic [W-1:0] sh_o,
  output logic         send_o
);

  logic         csn_prev_q;
  logic         sck_prev_q;
  logic         cs_fall;
  logic         sck_fall;
  sh_state_t    st_q, st_n;
  logic [W-1:0] sh_q, sh_n;
  logic         sh_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_prev_q <= 1'b1;
      sck_prev_q <= 1'b0;
    end else begin
      csn_prev_q <= csn_lvl_i;
      sck_prev_q <= sck_lvl_i;
    end
  end

  always_comb begin
    cs_fall  = ~csn_lvl_i & csn_prev_q;
    sck_fall = ~sck_lvl_i & sck_prev_q;
    st_n     = st_q;
    sh_n     = sh_q;
    sh_en    = 1'b0;
    if (cs_fall) begin
      st_n  = SH_SEND;
      sh_n  = par_i;
      sh_en = 1'b1;
    end else if (csn_lvl_i) begin
      st_n  = SH_IDLE;
    end else if ((st_q == SH_SEND) && sck_fall) begin
      sh_n  = {sh_q[W-2:0], 1'b0};
      sh_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SH_IDLE;
    end else begin
      st_q <= st_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sh_en) begin
      sh_q <= sh_n;
    end
  end

  assign sh_o   = sh_q;
  assign send_o = (st_q == SH_SEND);

endmodule

// File: rtl/evt_spi_counter.sv
module evt_spi_counter
  import evt_spi_pkg::*;
#(
  parameter int unsigned CNT_W  = CNT_W_DEF,
  parameter int unsigned SYNC_N = SYNC_N_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic spi_csn_i,
  input  logic spi_sck_i,
  output logic spi_miso_o,
  output logic spi_miso_oe_o
);

  localparam int unsigned MSB = CNT_W - 1;

  logic             rst_sync_n;
  logic             evt_lvl;
  logic             csn_lvl;
  logic             sck_lvl;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] sh_q;
  logic             send;

  evt_spi_rst_sync #(.STAGES(SYNC_N)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  evt_spi_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_sync_evt (
    .clk(clk), .rst_n(rst_sync_n), .d_i(evt_i), .q_o(evt_lvl)
  );

  evt_spi_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync_csn (
    .clk(clk), .rst_n(rst_sync_n), .d_i(spi_csn_i), .q_o(csn_lvl)
  );

  evt_spi_sync #(.STAGES(SYNC_N), .RST_VAL(1'b0)) u_sync_sck (
    .clk(clk), .rst_n(rst_sync_n), .d_i(spi_sck_i), .q_o(sck_lvl)
  );

  evt_spi_tally #(.W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_sync_n), .evt_lvl_i(evt_lvl), .cnt_o(cnt_q)
  );

  evt_spi_shifter #(.W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_sync_n), .csn_lvl_i(csn_lvl), .sck_lvl_i(sck_lvl),
    .par_i(cnt_q), .sh_o(sh_q), .send_o(send)
  );

  assign spi_miso_oe_o = send;
  assign spi_miso_o    = send ? sh_q[MSB] : 1'bz;

endmodule

// File: rtl/evt_spi_counter_chk.sv
module evt_spi_counter_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         evt_lvl,
  input logic         csn_lvl,
  input logic         sck_lvl,
  input logic [W-1:0] cnt,
  input logic [W-1:0] sh,
  input logic         oe
);

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == W'($past(cnt) + 1'b1)));

  // R1
  evt_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_lvl) |=> (cnt == W'($past(cnt) + 1'b1)));

  // R2
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csn_lvl |=> !oe);

  // R3
  snap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csn_lvl) |=> (oe && (sh == $past(cnt))));

  // R4
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && !csn_lvl && $fell(sck_lvl)) |=> (sh == {$past(sh[W-2:0]), 1'b0}));

  // R5
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && !$fell(sck_lvl) && !$fell(csn_lvl)) |=> $stable(sh));

endmodule

bind evt_spi_counter evt_spi_counter_chk #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .evt_lvl(evt_lvl), .csn_lvl(csn_lvl),
  .sck_lvl(sck_lvl), .cnt(cnt_q), .sh(sh_q), .oe(send)
);

// File: tb/test_evt_spi_counter.sv
`timescale 1ns/1ps
module test_evt_spi_counter;

  localparam int W  = 4;
  localparam int HP = 6;
  localparam int M  = 1 << W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, evt, csn, sck;
  wire  miso, oe;

  int tests = 0;
  int fails = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  evt_spi_counter #(.CNT_W(W)) i_evt_spi_counter (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .spi_csn_i(csn), .spi_sck_i(sck),
    .spi_miso_o(miso), .spi_miso_oe_o(oe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic pulse_evt;
    evt = 1'b1; tick(4);
    evt = 1'b0; tick(4);
    exp_cnt = (exp_cnt + 1) % M;
  endtask

  task automatic read_word(input bit pre, input bit evt_mid, input int expv, input string req);
    int got;
    got = 0;
    if (!pre) begin
      csn = 1'b0;
      tick(2); check("R3 enable not early", int'(oe), 0);
      tick(1); check("R3 enable on third edge", int'(oe), 1);
    end
    tick(4);
    for (int i = W - 1; i >= 0; i--) begin
      got = (got << 1) | int'(miso);
      sck = 1'b1; tick(HP);
      sck = 1'b0;
      if (evt_mid) begin
        evt = 1'b1; tick(3);
        evt = 1'b0; tick(HP - 3);
        exp_cnt = (exp_cnt + 1) % M;
      end else begin
        tick(HP);
      end
    end
    check(req, got, expv);
    csn = 1'b1; tick(6);
    check("R2 enable low after deselect", int'(oe), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int e;
    rst_n = 1'b0; evt = 1'b0; csn = 1'b1; sck = 1'b0;
    tick(3);
    check("R8 enable low in reset", int'(oe), 0);
    rst_n = 1'b1;
    tick(4);
    check("R2 idle enable low", int'(oe), 0);
    read_word(1'b0, 1'b0, 0, "R8 count zero after reset");

    // R1 R4: read after every event, across the wrap
    for (int k = 0; k < M + 4; k++) begin
      pulse_evt();
      read_word(1'b0, 1'b0, exp_cnt, "R1 R4 sweep value");
    end

    // R5: events between serial clock edges
    e = exp_cnt;
    read_word(1'b0, 1'b1, e, "R5 snapshot held during events");
    read_word(1'b0, 1'b0, exp_cnt, "R5 live count kept running");

    // R6: event edge aligned with select edge
    e = exp_cnt;
    evt = 1'b1; csn = 1'b0;
    tick(4);
    evt = 1'b0;
    exp_cnt = (exp_cnt + 1) % M;
    tick(4);
    read_word(1'b1, 1'b0, e, "R6 coincident event not in snapshot");
    read_word(1'b0, 1'b0, exp_cnt, "R6 coincident event counted");

    // R7: abandoned transfer then fresh snapshot
    csn = 1'b0; tick(8);
    for (int j = 0; j < 2; j++) begin
      sck = 1'b1; tick(HP);
      sck = 1'b0; tick(HP);
    end
    csn = 1'b1; tick(6);
    check("R7 enable low after abandon", int'(oe), 0);
    pulse_evt();
    read_word(1'b0, 1'b0, exp_cnt, "R7 fresh snapshot after abandon");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule